// File: doc/BRIEF.md
# Smart Card Answer-To-Reset Parser

This block follows the Answer-To-Reset sequence that a smart card sends once its reset is released. A character receiver upstream hands it one byte per strobe. A start pulse arms the parser and clears its state. The parser then tracks where each byte sits in the sequence: the initial character, the format byte, the chain of optional interface bytes, the historical bytes and the single check byte.

From the first TA interface byte it takes the clock-rate index and the baud-adjustment index. It converts them into a clocks-per-elementary-time-unit divisor for the receiver, and reports this together with a done flag once the check byte has arrived. Every accepted byte is also kept in an internal buffer. A read port gives access to the buffer, and a byte count and an overflow flag go with it.

The parser never checks the value of the check byte. It does not detect the inverse convention and it does not negotiate the protocol.

Top module: `atr_parser`

## Requirements
- R1: After reset, and until the first start pulse, done, divisor-valid and overflow are 0, the byte count is 0, the divisor reads 372, and received bytes are ignored.
- R2: While the parser waits for the initial character, a byte of value 0x00 is dropped and is neither stored nor counted. The first non-zero byte is accepted as the initial character, and the parser then expects the format byte.
- R3: The format byte's low nibble is the historical-byte count and its high nibble is the presence indicator. Indicator bit 4 (0x10) announces TA, bit 5 (0x20) TB, bit 6 (0x40) TC and bit 7 (0x80) TD. These bytes follow strictly in that order, and absent ones are skipped. Each TD byte becomes the new indicator, including its low nibble.
- R4: A TA byte supplies the rate indices only while the stored indicator's low nibble is 0. Its upper nibble is the Fi index and its lower nibble is the Di index. Any other TA byte leaves both indices unchanged.
- R5: F over Fi index 0..15 is 0,372,558,744,1116,1488,1860,0,0,512,768,1024,1536,2048,0,0. D over Di index 0..15 is 0,1,2,4,8,16,0,0,0,0,2,4,8,16,32,64. The ratio is F/D for a Di index below 8 and F·D otherwise. It is valid only if both table entries are non-zero and the ratio lies in 1..1023. When done, a valid ratio appears on the 10-bit divisor with divisor-valid 1; otherwise the divisor stays 372 with divisor-valid 0.
- R6: After the last historical byte, or directly after the interface bytes when the count is 0, exactly one more byte is consumed as the check byte. Done rises in the cycle after that byte and holds until the next start.
- R7: A start pulse clears the byte count, the overflow flag, done, divisor-valid and every buffer entry. It resets both indices to 1 (divisor 372), and the parser then waits for the initial character.
- R8: Every accepted byte, from the initial character to the check byte, is written to the buffer at the index equal to the current byte count, and the count increments by one.
- R9: Once 64 bytes are held, further accepted bytes are dropped and the overflow flag rises and stays set until the next start. The count never exceeds 64.
- R10: Bytes received after done are ignored: the count, the buffer and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that clears the state and arms parsing |
| rx_valid_i | input | 1 | Strobe: rx_byte_i holds a received byte |
| rx_byte_i | input | 8 | Received byte |
| rd_addr_i | input | 6 | Buffer read index |
| rd_data_o | output | 8 | Buffer entry at rd_addr_i (combinational) |
| byte_count_o | output | 7 | Number of bytes stored |
| overflow_o | output | 1 | A byte was dropped because the buffer was full |
| done_o | output | 1 | Check byte consumed |
| divisor_o | output | 10 | Clocks per elementary time unit |
| divisor_ok_o | output | 1 | The ratio from the captured indices was in range |

## Verification
Every result is a single register away from its strobe. The count, the overflow flag, the buffer entry, done and the divisor all settle at the first rising edge that sees the byte or the start pulse. The bench drives on the falling edge, holds the strobe for one cycle and checks at the following falling edge, so each check falls exactly one edge after its stimulus. Buffer reads are combinational: the address is set and then sampled one time step later in the same half-cycle. The divisor is checked for all 256 values of the first TA byte against tables held in the bench.

// File: rtl/atr_pkg.sv
// Package: shared parser state type and the rate-table lookups.
// Assumes indices are 4-bit nibbles; lookups are pure combinational functions.
package atr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_INIT, ST_FMT, ST_IA, ST_IB, ST_IC, ST_ID,
        ST_HIST, ST_CHK, ST_DONE
    } atr_state_e;

    localparam int unsigned DIV_W      = 10;
    localparam int unsigned RATIO_W    = 18;
    localparam logic [3:0]  IDX_DEF    = 4'd1;
    localparam logic [DIV_W-1:0] DIV_DEF = 10'd372;

    // Clock-rate factor for an Fi index; zero marks a reserved index.
    function automatic logic [11:0] rate_f(input logic [3:0] idx);
        case (idx)
            4'd1:    rate_f = 12'd372;
            4'd2:    rate_f = 12'd558;
            4'd3:    rate_f = 12'd744;
            4'd4:    rate_f = 12'd1116;
            4'd5:    rate_f = 12'd1488;
            4'd6:    rate_f = 12'd1860;
            4'd9:    rate_f = 12'd512;
            4'd10:   rate_f = 12'd768;
            4'd11:   rate_f = 12'd1024;
            4'd12:   rate_f = 12'd1536;
            4'd13:   rate_f = 12'd2048;
            default: rate_f = 12'd0;
        endcase
    endfunction

    // Adjustment factor for a Di index as {valid, log2}; all factors are powers of two.
    function automatic logic [3:0] rate_d(input logic [3:0] idx);
        case (idx)
            4'd1:    rate_d = {1'b1, 3'd0};
            4'd2:    rate_d = {1'b1, 3'd1};
            4'd3:    rate_d = {1'b1, 3'd2};
            4'd4:    rate_d = {1'b1, 3'd3};
            4'd5:    rate_d = {1'b1, 3'd4};
            4'd10:   rate_d = {1'b1, 3'd1};
            4'd11:   rate_d = {1'b1, 3'd2};
            4'd12:   rate_d = {1'b1, 3'd3};
            4'd13:   rate_d = {1'b1, 3'd4};
            4'd14:   rate_d = {1'b1, 3'd5};
            4'd15:   rate_d = {1'b1, 3'd6};
            default: rate_d = 4'd0;
        endcase
    endfunction

    // Next expected byte: scan the indicator from slot 'from' (0=A..3=D) onward.
    function automatic atr_state_e next_slot(input logic [1:0] from,
                                             input logic [3:0] ind,
                                             input logic       no_hist);
        if (from == 2'd0 && ind[0])      next_slot = ST_IA;
        else if (from <= 2'd1 && ind[1]) next_slot = ST_IB;
        else if (from <= 2'd2 && ind[2]) next_slot = ST_IC;
        else if (ind[3])                 next_slot = ST_ID;
        else if (no_hist)                next_slot = ST_CHK;
        else                             next_slot = ST_HIST;
    endfunction

endpackage

// File: rtl/atr_ratio.sv
// Module: turns the captured rate indices into a divisor and a range flag.
// Assumes the indices are stable while the result is used; purely combinational.
module atr_ratio
    import atr_pkg::*;
(
    input  logic [3:0]       fi_i,
    input  logic [3:0]       di_i,
    output logic [DIV_W-1:0] ratio_o,
    output logic             ratio_ok_o
);
    logic [11:0]        f_val;
    logic [3:0]         d_code;
    logic [RATIO_W-1:0] full;

    // Scale F by D using shifts, multiplying for the upper half of the Di range.
    always_comb begin
        f_val  = rate_f(fi_i);
        d_code = rate_d(di_i);
        if (di_i[3]) full = RATIO_W'(f_val) << d_code[2:0];
        else         full = RATIO_W'(f_val >> d_code[2:0]);
        ratio_ok_o = (f_val != 12'd0) && d_code[3] && (full != '0)
                     && (full < RATIO_W'(1 << DIV_W));
        ratio_o    = full[DIV_W-1:0];
    end
endmodule

// File: rtl/atr_store.sv
// Module: byte buffer with a fill count and a sticky overflow flag.
// Assumes clr_i and wr_i are never needed in the same cycle (clear wins).
module atr_store #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [7:0]    wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    output logic [CW-1:0] count_o,
    output logic          overflow_o
);
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] count_q;
    logic          ovf_q;

    // Clear, append at the fill index, or flag the drop once full.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (wr_i) begin
            if (count_q < CW'(DEPTH)) begin
                mem[count_q[AW-1:0]] <= wr_data_i;
                count_q <= count_q + 1'b1;
            end else begin
                ovf_q <= 1'b1;
            end
        end
    end

    // Asynchronous read of one entry.
    always_comb rd_data_o = mem[rd_addr_i];

    assign count_o    = count_q;
    assign overflow_o = ovf_q;
endmodule

// File: rtl/atr_seq.sv
// Module: sequence tracker for the answer-to-reset byte stream.
// Assumes one byte per rx_valid_i strobe; start_i has priority over a byte.
module atr_seq
    import atr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_byte_i,
    input  logic [DIV_W-1:0] ratio_i,
    input  logic             ratio_ok_i,
    output logic [3:0]       fi_o,
    output logic [3:0]       di_o,
    output logic             store_o,
    output logic             done_o,
    output logic [DIV_W-1:0] divisor_o,
    output logic             divisor_ok_o
);
    atr_state_e       state_q;
    logic [7:0]       ind_q;
    logic [3:0]       hist_q;
    logic [3:0]       fi_q, di_q;
    logic             done_q, ok_q;
    logic [DIV_W-1:0] div_q;
    logic             active;

    // A byte is stored in every parsing state except a zero while waiting for the first.
    always_comb begin
        active  = (state_q != ST_IDLE) && (state_q != ST_DONE);
        store_o = rx_valid_i && !start_i && active
                  && !(state_q == ST_INIT && rx_byte_i == 8'h00);
    end

    // State, indicator, historical count, rate indices and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            state_q <= rst_n ? ST_INIT : ST_IDLE;
            ind_q   <= 8'h00;
            hist_q  <= 4'd0;
            fi_q    <= IDX_DEF;
            di_q    <= IDX_DEF;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            div_q   <= DIV_DEF;
        end else if (rx_valid_i) begin
            case (state_q)
                ST_INIT: if (rx_byte_i != 8'h00) state_q <= ST_FMT;
                ST_FMT: begin
                    hist_q  <= rx_byte_i[3:0];
                    ind_q   <= {rx_byte_i[7:4], 4'h0};
                    state_q <= next_slot(2'd0, rx_byte_i[7:4], rx_byte_i[3:0] == 4'd0);
                end
                ST_IA: begin
                    if (ind_q[3:0] == 4'h0) begin
                        fi_q <= rx_byte_i[7:4];
                        di_q <= rx_byte_i[3:0];
                    end
                    state_q <= next_slot(2'd1, ind_q[7:4], hist_q == 4'd0);
                end
                ST_IB: state_q <= next_slot(2'd2, ind_q[7:4], hist_q == 4'd0);
                ST_IC: state_q <= next_slot(2'd3, ind_q[7:4], hist_q == 4'd0);
                ST_ID: begin
                    ind_q   <= rx_byte_i;
                    state_q <= next_slot(2'd0, rx_byte_i[7:4], hist_q == 4'd0);
                end
                ST_HIST: begin
                    hist_q <= hist_q - 1'b1;
                    if (hist_q == 4'd1) state_q <= ST_CHK;
                end
                ST_CHK: begin
                    state_q <= ST_DONE;
                    done_q  <= 1'b1;
                    ok_q    <= ratio_ok_i;
                    if (ratio_ok_i) div_q <= ratio_i;
                end
                default: ;
            endcase
        end
    end

    assign fi_o         = fi_q;
    assign di_o         = di_q;
    assign done_o       = done_q;
    assign divisor_o    = div_q;
    assign divisor_ok_o = ok_q;
endmodule

// File: rtl/atr_parser.sv
// Module: top of the answer-to-reset parser; joins tracker, ratio unit and buffer.
// Assumes a byte-level receiver upstream and a synchronous active-low reset.
module atr_parser
    import atr_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_byte_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [7:0]       rd_data_o,
    output logic [CW-1:0]    byte_count_o,
    output logic             overflow_o,
    output logic             done_o,
    output logic [DIV_W-1:0] divisor_o,
    output logic             divisor_ok_o
);
    logic [3:0]       fi, di;
    logic [DIV_W-1:0] ratio;
    logic             ratio_ok, store;

    atr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
        .ratio_i(ratio), .ratio_ok_i(ratio_ok),
        .fi_o(fi), .di_o(di), .store_o(store),
        .done_o(done_o), .divisor_o(divisor_o), .divisor_ok_o(divisor_ok_o)
    );

    atr_ratio u_ratio (
        .fi_i(fi), .di_i(di), .ratio_o(ratio), .ratio_ok_o(ratio_ok)
    );

    atr_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i),
        .wr_i(store), .wr_data_i(rx_byte_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .count_o(byte_count_o), .overflow_o(overflow_o)
    );
endmodule

// File: rtl/atr_parser_chk.sv
// Module: checker bound to the parser top; observes ports only.
// Assumes the synchronous active-low reset; arms one cycle after reset is released.
module atr_parser_chk #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [CW-1:0] byte_count_o,
    input logic          overflow_o,
    input logic          done_o,
    input logic [9:0]    divisor_o,
    input logic          divisor_ok_o
);
    logic armed;

    // Marks that at least one cycle out of reset has passed.
    always_ff @(posedge clk) armed <= rst_n;

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_count_o <= CW'(DEPTH));

    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && overflow_o && !start_i) |=> overflow_o);

    p_overflow_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(overflow_o)) |-> byte_count_o == CW'(DEPTH));

    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (byte_count_o == '0 && !overflow_o && !done_o && !divisor_ok_o));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !start_i) |=> (byte_count_o == $past(byte_count_o)
                                 || byte_count_o == $past(byte_count_o) + 1'b1));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && done_o && !start_i) |=> (done_o && $stable(divisor_o) && $stable(divisor_ok_o)));

    p_ok_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        divisor_ok_o |-> (done_o && divisor_o != 10'd0));
endmodule

bind atr_parser atr_parser_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .byte_count_o(byte_count_o), .overflow_o(overflow_o), .done_o(done_o),
    .divisor_o(divisor_o), .divisor_ok_o(divisor_ok_o)
);

// File: tb/atr_parser_bench.sv
module atr_parser_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_byte_i = 8'h00;
    logic [5:0] rd_addr_i = 6'd0;
    logic [7:0] rd_data_o;
    logic [6:0] byte_count_o;
    logic       overflow_o, done_o, divisor_ok_o;
    logic [9:0] divisor_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    int f_tab [16] = '{0,372,558,744,1116,1488,1860,0,0,512,768,1024,1536,2048,0,0};
    int d_tab [16] = '{0,1,2,4,8,16,0,0,0,0,2,4,8,16,32,64};

    always #5 clk = ~clk;

    atr_parser u_atr_parser (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .byte_count_o(byte_count_o), .overflow_o(overflow_o),
        .done_o(done_o), .divisor_o(divisor_o), .divisor_ok_o(divisor_ok_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_byte_i  = b;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic peek(input int addr, output int val);
        rd_addr_i = 6'(addr);
        #1;
        val = int'(rd_data_o);
    endtask

    initial begin
        int v;
        int f, d, r;
        bit ok;
        logic [7:0] seq [13] = '{8'h3B, 8'hF3, 8'h95, 8'h00, 8'h00, 8'h81, 8'h31,
                                 8'h11, 8'h45, 8'h01, 8'h02, 8'h03, 8'hAB};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "done", done_o, 0);
        check("R1", "divisor", divisor_o, 372);
        check("R1", "ok", divisor_ok_o, 0);
        check("R1", "overflow", overflow_o, 0);
        check("R1", "count", byte_count_o, 0);
        send(8'h3B);
        check("R1", "idle byte ignored", byte_count_o, 0);

        // R2 zero skipped before the initial character
        pulse_start();
        send(8'h00); send(8'h00);
        check("R2", "zeros not counted", byte_count_o, 0);
        send(8'h3B);
        check("R2", "first nonzero counted", byte_count_o, 1);
        peek(0, v);
        check("R2", "buf0", v, 8'h3B);

        // R3 R4 R6 R8 full interface chain
        pulse_start();
        for (int i = 0; i < 12; i++) send(seq[i]);
        check("R6", "not done before check byte", done_o, 0);
        check("R8", "count before check byte", byte_count_o, 12);
        send(seq[12]);
        check("R3", "done after chain", done_o, 1);
        check("R4", "TA1 used, later TA ignored", divisor_o, 32);
        check("R5", "ok", divisor_ok_o, 1);
        for (int i = 0; i < 13; i++) begin
            peek(i, v);
            check("R8", $sformatf("buf%0d", i), v, seq[i]);
        end
        // R10 after done
        send(8'h77);
        check("R10", "count after done", byte_count_o, 13);
        check("R10", "divisor after done", divisor_o, 32);
        peek(13, v);
        check("R10", "buf13", v, 0);

        // R6 zero historical bytes go straight to the check byte
        pulse_start();
        send(8'h3B); send(8'h00);
        check("R6", "not done after format", done_o, 0);
        send(8'h5A);
        check("R6", "done after check byte", done_o, 1);
        check("R6", "default divisor", divisor_o, 372);
        check("R5", "default valid", divisor_ok_o, 1);

        // R5 sweep of all first-TA values
        for (int ta = 0; ta < 256; ta++) begin
            pulse_start();
            send(8'h3B); send(8'h10); send(8'(ta));
            check("R6", "not done before check", done_o, 0);
            send(8'h00);
            f = f_tab[ta >> 4];
            d = d_tab[ta & 15];
            r = 0;
            if (d != 0) r = ((ta & 15) < 8) ? f / d : f * d;
            ok = (f != 0) && (d != 0) && (r > 0) && (r < 1024);
            check("R5", $sformatf("ok ta=%0h", ta), divisor_ok_o, ok);
            check("R5", $sformatf("div ta=%0h", ta), divisor_o, ok ? r : 372);
        end

        // R9 overflow with a long TD chain
        pulse_start();
        send(8'h3B); send(8'h8F);
        for (int i = 0; i < 50; i++) send(8'h80);
        send(8'h00);
        for (int k = 0; k < 15; k++) begin
            send(8'(8'hA0 + k));
            if (k == 10) begin
                check("R9", "count at full", byte_count_o, 64);
                check("R9", "no overflow at full", overflow_o, 0);
            end
            if (k == 11) check("R9", "overflow on 65th", overflow_o, 1);
        end
        send(8'hCC);
        check("R9", "count capped", byte_count_o, 64);
        check("R9", "overflow held", overflow_o, 1);
        check("R6", "done despite overflow", done_o, 1);
        peek(63, v);
        check("R9", "last stored", v, 8'hAA);

        // R7 start clears
        pulse_start();
        check("R7", "count", byte_count_o, 0);
        check("R7", "overflow", overflow_o, 0);
        check("R7", "done", done_o, 0);
        check("R7", "ok", divisor_ok_o, 0);
        check("R7", "divisor", divisor_o, 372);
        peek(0, v);
        check("R7", "buf0 cleared", v, 0);
        peek(63, v);
        check("R7", "buf63 cleared", v, 0);
        send(8'h00);
        check("R7", "waits for initial char", byte_count_o, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule